// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This unit sits beside a processor core's control path. It looks at seven exception request lines every clock and picks the single most urgent one. The choice takes account of the fast- and normal-interrupt mask bits held in the current status word. For that one exception it produces, one clock later, an entry strobe and the handler address. The handler address sits in a low or a relocated high vector block. Alongside the strobe it gives the processor mode to switch into, the return link, the status word the core should adopt, and the status word to keep for the return.

Requests are levels. The unit keeps no queue. A request that loses arbitration is served on a later entry if its source still drives it. After each entry the unit pauses for one cycle. In that cycle the core can load the new status word, so the new mask bits apply before the next decision. Pipeline flushing and the handler instruction fetch belong to the core.

Top module: `exc_entry_unit`

## Requirements
- R1: Among the qualified requests, the winner is chosen in this order from highest to lowest: reset (req_i[0]), data abort (req_i[4]), fast interrupt (req_i[6]), normal interrupt (req_i[5]), prefetch abort (req_i[3]), undefined instruction (req_i[1]), software interrupt (req_i[2]). When both undefined and software interrupt are raised, undefined wins.
- R2: A fast-interrupt request is ignored while status_i[6] is 1. A normal-interrupt request is ignored while status_i[7] is 1. With no other request present, entry_o stays 0.
- R3: vector_o is a base plus an offset. The base is 0 when hi_vec_i is 0 and 0xFFFF0000 when it is 1. The offset is 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt. Offset 0x14 is never produced.
- R4: mode_o is 0x13 for reset and software interrupt, 0x1B for undefined, 0x17 for both aborts, 0x12 for normal interrupt and 0x11 for fast interrupt.
- R5: link_o is pc_i + 4 for every exception except reset, for which it is 0.
- R6: new_status_o equals status_i with these changes: bits [4:0] replaced by mode_o and bit 7 set. Bit 6 is set for reset and fast interrupt and keeps its value otherwise. All other bits are copied unchanged.
- R7: On an entry for any exception other than reset, saved_we_o is 1 and saved_status_o equals the status_i that was sampled. A reset entry leaves saved_we_o at 0.
- R8: Inputs sampled at one rising edge give outputs valid right after that edge. entry_o is high for one cycle only. The cycle after an entry takes no exception, even if requests are still held.
- R9: A lower-priority request that stays asserted is taken on a later entry once the higher ones have gone.
- R10: While rst is 1, entry_o, saved_we_o and vector_o are cleared to 0 at each rising edge, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Exception request levels, bit positions as in R1 |
| hi_vec_i | input | 1 | Selects the high vector base |
| pc_i | input | ADDR_W | Address of the interrupted instruction |
| status_i | input | STAT_W | Current status word (mode [4:0], fast mask 6, normal mask 7) |
| entry_o | output | 1 | One-cycle exception entry strobe |
| vector_o | output | ADDR_W | Handler address |
| mode_o | output | 5 | Mode to enter |
| link_o | output | ADDR_W | Return link value |
| new_status_o | output | STAT_W | Status word to load on entry |
| saved_status_o | output | STAT_W | Status word to keep for the return |
| saved_we_o | output | 1 | Saved status write strobe |

## Verification
Every result is due one clock after its inputs are sampled, because a single register stage lies between the request lines and all outputs. The bench therefore drives inputs on a falling edge and reads outputs on the next falling edge. After each taken entry it reads the following cycle to confirm the one-cycle pause. The sweep also drops the requests for a cycle after every case, so each new case starts when the unit is ready to take an exception and its expected result lands exactly one edge later. The held-request sequences count edges in the same way: entry, pause, entry.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

  localparam int NUM_EXC = 7;
  localparam int MODE_W  = 5;
  localparam int I_BIT   = 7;
  localparam int F_BIT   = 6;

  // request line positions
  localparam int REQ_RESET = 0;
  localparam int REQ_UNDEF = 1;
  localparam int REQ_SWI   = 2;
  localparam int REQ_PABT  = 3;
  localparam int REQ_DABT  = 4;
  localparam int REQ_IRQ   = 5;
  localparam int REQ_FIQ   = 6;

  // slot code equals vector offset divided by four; code 5 is reserved
  typedef enum logic [2:0] {
    SLOT_RESET = 3'd0,
    SLOT_UNDEF = 3'd1,
    SLOT_SWI   = 3'd2,
    SLOT_PABT  = 3'd3,
    SLOT_DABT  = 3'd4,
    SLOT_IRQ   = 3'd6,
    SLOT_FIQ   = 3'd7
  } exc_slot_e;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SUP = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  // rank 0 is the most urgent
  function automatic int rank_to_line(int rank);
    case (rank)
      0:       return REQ_RESET;
      1:       return REQ_DABT;
      2:       return REQ_FIQ;
      3:       return REQ_IRQ;
      4:       return REQ_PABT;
      5:       return REQ_UNDEF;
      default: return REQ_SWI;
    endcase
  endfunction

  function automatic exc_slot_e line_to_slot(int line);
    case (line)
      REQ_RESET: return SLOT_RESET;
      REQ_UNDEF: return SLOT_UNDEF;
      REQ_SWI:   return SLOT_SWI;
      REQ_PABT:  return SLOT_PABT;
      REQ_DABT:  return SLOT_DABT;
      REQ_IRQ:   return SLOT_IRQ;
      default:   return SLOT_FIQ;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] slot_mode(exc_slot_e s);
    case (s)
      SLOT_UNDEF:             return MODE_UND;
      SLOT_PABT, SLOT_DABT:   return MODE_ABT;
      SLOT_IRQ:               return MODE_IRQ;
      SLOT_FIQ:               return MODE_FIQ;
      default:                return MODE_SUP;
    endcase
  endfunction

endpackage

// File: rtl/exc_prio_sel.sv
`timescale 1ns/1ps
module exc_prio_sel
  import exc_entry_pkg::*;
(
  input  logic [NUM_EXC-1:0] req_i,
  input  logic               f_mask_i,
  input  logic               i_mask_i,
  output logic               hit_o,
  output exc_slot_e          slot_o
);

  logic [NUM_EXC-1:0] qual;

  genvar g;
  generate
    for (g = 0; g < NUM_EXC; g++) begin : g_qual
      if (g == REQ_FIQ) begin : g_f
        assign qual[g] = req_i[g] & ~f_mask_i;
      end else if (g == REQ_IRQ) begin : g_i
        assign qual[g] = req_i[g] & ~i_mask_i;
      end else begin : g_p
        assign qual[g] = req_i[g];
      end
    end
  endgenerate

  // walk from least to most urgent so the most urgent overwrites
  always_comb begin
    hit_o  = 1'b0;
    slot_o = SLOT_RESET;
    for (int r = NUM_EXC - 1; r >= 0; r--) begin
      if (qual[rank_to_line(r)]) begin
        hit_o  = 1'b1;
        slot_o = line_to_slot(rank_to_line(r));
      end
    end
  end

endmodule

// File: rtl/exc_entry_map.sv
`timescale 1ns/1ps
module exc_entry_map
  import exc_entry_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              STAT_W   = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000,
  parameter int              LINK_OFF = 4
) (
  input  exc_slot_e          slot_i,
  input  logic               hi_vec_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic [ADDR_W-1:0]  vector_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic [ADDR_W-1:0]  link_o,
  output logic [STAT_W-1:0]  new_status_o,
  output logic               save_o
);

  localparam int OFF_W = 5;

  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] base;
  logic              is_reset;

  assign is_reset = (slot_i == SLOT_RESET);
  assign offset   = {slot_i, 2'b00};
  assign base     = hi_vec_i ? HI_BASE : '0;
  assign vector_o = base | ADDR_W'(offset);
  assign mode_o   = slot_mode(slot_i);
  assign link_o   = is_reset ? '0 : pc_i + ADDR_W'(LINK_OFF);
  assign save_o   = ~is_reset;

  always_comb begin
    new_status_o           = status_i;
    new_status_o[MODE_W-1:0] = mode_o;
    new_status_o[I_BIT]    = 1'b1;
    if (is_reset || slot_i == SLOT_FIQ) new_status_o[F_BIT] = 1'b1;
  end

endmodule

// File: rtl/exc_entry_unit.sv
`timescale 1ns/1ps
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_EXC-1:0]        req_i,
  input  logic                      hi_vec_i,
  input  logic [ADDR_W-1:0]         pc_i,
  input  logic [STAT_W-1:0]         status_i,
  output logic                      entry_o,
  output logic [ADDR_W-1:0]         vector_o,
  output logic [MODE_W-1:0]         mode_o,
  output logic [ADDR_W-1:0]         link_o,
  output logic [STAT_W-1:0]         new_status_o,
  output logic [STAT_W-1:0]         saved_status_o,
  output logic                      saved_we_o
);

  logic              hit;
  exc_slot_e         slot;
  logic              take;
  logic              pause_q;
  logic [ADDR_W-1:0] vec_d, link_d;
  logic [MODE_W-1:0] mode_d;
  logic [STAT_W-1:0] stat_d;
  logic              save_d;

  exc_prio_sel u_sel (
    .req_i    (req_i),
    .f_mask_i (status_i[F_BIT]),
    .i_mask_i (status_i[I_BIT]),
    .hit_o    (hit),
    .slot_o   (slot)
  );

  exc_entry_map #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_map (
    .slot_i       (slot),
    .hi_vec_i     (hi_vec_i),
    .pc_i         (pc_i),
    .status_i     (status_i),
    .vector_o     (vec_d),
    .mode_o       (mode_d),
    .link_o       (link_d),
    .new_status_o (stat_d),
    .save_o       (save_d)
  );

  assign take = hit & ~pause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_q        <= 1'b0;
      entry_o        <= 1'b0;
      saved_we_o     <= 1'b0;
      vector_o       <= '0;
      mode_o         <= '0;
      link_o         <= '0;
      new_status_o   <= '0;
      saved_status_o <= '0;
    end else begin
      pause_q    <= take;
      entry_o    <= take;
      saved_we_o <= take & save_d;
      if (take) begin
        vector_o     <= vec_d;
        mode_o       <= mode_d;
        link_o       <= link_d;
        new_status_o <= stat_d;
        if (save_d) saved_status_o <= status_i;
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_EXC-1:0]   req_i,
  input logic [STAT_W-1:0]    status_i,
  input logic                 entry_o,
  input logic [ADDR_W-1:0]    vector_o,
  input logic [MODE_W-1:0]    mode_o,
  input logic [STAT_W-1:0]    new_status_o,
  input logic                 saved_we_o
);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    entry_o |=> !entry_o);

  // R3
  vec_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    entry_o |-> (vector_o[4:0] != 5'h14 && vector_o[1:0] == 2'b00));

  // R6
  imask_set_chk: assert property (@(posedge clk) disable iff (rst)
    entry_o |-> new_status_o[I_BIT]);

  // R6
  fmask_fiq_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_o && mode_o == MODE_FIQ) |-> new_status_o[F_BIT]);

  // R7
  save_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    saved_we_o |-> entry_o);

  // R1
  reset_first_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_o && $past(req_i[REQ_RESET])) |-> (vector_o[4:0] == 5'h00 && !saved_we_o));

  // R2
  fiq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_o && $past(status_i[F_BIT])) |-> mode_o != MODE_FIQ);

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!entry_o && !saved_we_o));

endmodule

bind exc_entry_unit exc_entry_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_i        (req_i),
  .status_i     (status_i),
  .entry_o      (entry_o),
  .vector_o     (vector_o),
  .mode_o       (mode_o),
  .new_status_o (new_status_o),
  .saved_we_o   (saved_we_o)
);

// File: tb/exc_entry_unit_tb_top.sv
`timescale 1ns/1ps
module exc_entry_unit_tb_top;

  localparam int AW = 32;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [6:0]    req;
  logic          hv;
  logic [AW-1:0] pc;
  logic [SW-1:0] st;
  logic          entry, swe;
  logic [AW-1:0] vec, link;
  logic [4:0]    mode;
  logic [SW-1:0] nst, sst;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_unit #(.ADDR_W(AW), .STAT_W(SW)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .hi_vec_i(hv), .pc_i(pc),
    .status_i(st), .entry_o(entry), .vector_o(vec), .mode_o(mode),
    .link_o(link), .new_status_o(nst), .saved_status_o(sst),
    .saved_we_o(swe)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int ord_line(int k);
    case (k)
      0: return 0; 1: return 4; 2: return 6; 3: return 5;
      4: return 3; 5: return 1; default: return 2;
    endcase
  endfunction

  function automatic int pick(logic [6:0] r, logic fm, logic im);
    for (int k = 0; k < 7; k++) begin
      int i;
      i = ord_line(k);
      if (r[i] && !(i == 6 && fm) && !(i == 5 && im)) return i;
    end
    return -1;
  endfunction

  function automatic logic [31:0] off_of(int i);
    case (i)
      0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
      4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(int i);
    case (i)
      0, 2: return 5'h13; 1: return 5'h1B; 3, 4: return 5'h17;
      5: return 5'h12; default: return 5'h11;
    endcase
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(logic [6:0] r, logic fm, logic im, logic h, int idx);
    int p;
    logic [31:0] e_st;
    req = r; hv = h;
    pc  = 32'h0000_2000 + 32'(idx) * 16;
    st  = 32'h5A3C_0000 | (32'(im) << 7) | (32'(fm) << 6) | (32'(idx & 1) << 5) | 32'h10;
    step();
    p = pick(r, fm, im);
    if (p < 0) begin
      chk("R1 R2", "no entry", 32'(entry), 32'd0);
    end else begin
      chk("R1 R2", "entry", 32'(entry), 32'd1);
      chk("R1 R3", "vector", vec, (h ? 32'hFFFF_0000 : 32'h0) | off_of(p));
      chk("R4", "mode", 32'(mode), 32'(mode_of(p)));
      chk("R5", "link", link, (p == 0) ? 32'h0 : pc + 32'd4);
      e_st = (st & ~32'h0000_00DF) | 32'(mode_of(p)) | 32'h80 |
             ((p == 0 || p == 6 || fm) ? 32'h40 : 32'h0);
      chk("R6", "new status", nst, e_st);
      chk("R7", "save strobe", 32'(swe), (p == 0) ? 32'd0 : 32'd1);
      if (p != 0) chk("R7", "saved status", sst, st);
    end
    req = '0;
    step();
    chk("R8", "idle after case", 32'(entry), 32'd0);
  endtask

  initial begin
    rst = 1'b1; req = '0; hv = 1'b0; pc = '0; st = 32'h10;
    @(negedge clk);
    req = 7'h7F;
    step(); step();
    // R10: cleared state while held in reset
    chk("R10", "entry in reset", 32'(entry), 32'd0);
    chk("R10", "save in reset", 32'(swe), 32'd0);
    chk("R10", "vector in reset", vec, 32'd0);
    rst = 1'b0; req = '0;
    step();

    // near-exhaustive sweep
    for (int h = 0; h < 2; h++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 128; r++)
          run_case(7'(r), m[0], m[1], h[0], r + 128 * m);

    // R8: held request alternates entry and pause
    hv = 1'b0; st = 32'h10; pc = 32'h100; req = 7'b010_0000;
    step(); chk("R8", "held 1st", 32'(entry), 32'd1);
    step(); chk("R8", "held pause", 32'(entry), 32'd0);
    step(); chk("R8", "held 2nd", 32'(entry), 32'd1);
    step(); chk("R8", "held pause 2", 32'(entry), 32'd0);
    req = '0; step();

    // R9: lower request stays pending
    req = 7'b011_0000;
    step(); chk("R9", "data abort first", vec, 32'h10);
    step(); chk("R9", "pause", 32'(entry), 32'd0);
    req = 7'b010_0000;
    step(); chk("R9", "irq entry", 32'(entry), 32'd1);
    chk("R9", "irq vector", vec, 32'h18);
    req = '0; step();

    // R9: fast interrupt then prefetch abort
    req = 7'b100_1000;
    step(); chk("R9", "fiq first", vec, 32'h1C);
    step();
    req = 7'b000_1000;
    step(); chk("R9", "pabort later", vec, 32'h0C);
    req = '0; step();

    // R10: reset mid-run overrides a request
    req = 7'b000_0001; rst = 1'b1;
    step(); chk("R10", "reset overrides", 32'(entry), 32'd0);
    rst = 1'b0; req = '0; step();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule